// File: doc/BRIEF.md
# First-Order Pulse-Density DAC Modulator

This block turns an unsigned digital level into a single-bit pulse stream whose fraction of high cycles matches the level divided by 2^DW. An external RC low-pass filter averages the stream into a DC voltage between ground and the I/O supply. One input LSB moves the filtered voltage by 1/2^DW of full scale. Because of this, the block suits slowly varying control voltages, bias settings and reference levels.

A signed accumulator of DW+2 bits integrates the difference between the input and the previous output decision. Its top bit is the decision. Two copies of that bit fill the top two positions of the feedback word. This one word both removes the output's contribution and offsets the unsigned input, so no separate comparator is needed. The decision passes through one more flip-flop before it reaches the pin.

Top module: `pdm_dac`

## Requirements
- R1: With `level_i` held at 0 from reset onward, `pulse_o` never goes high.
- R2: With `level_i` at all ones (2^DW-1), each window of 4*2^DW cycles taken after settling holds 4*(2^DW-1) high cycles, within ±1. The stream is therefore not constantly high.
- R3: For every unsigned value V of `level_i` held steady, each window of 2^DW consecutive cycles taken after settling holds V high cycles, within ±1.
- R4: While `rst` is high, `pulse_o` is 0. The accumulator loads 2^DW, which is bit DW set and all other bits clear. For the first two rising edges after `rst` falls, `pulse_o` stays 0 whatever the input.
- R5: The accumulator never wraps. Its value always lies in [2^DW, 3*2^DW), so its top two bits are always 01 or 10.
- R6: After a cycle with the accumulator's top bit set, the accumulator's value falls, because 2^DW is subtracted and less than 2^DW is added. After a cycle with that bit clear, the value does not fall.
- R7: When `level_i` changes in mid-stream without a reset, the high count in each window of 2^DW cycles starting 2^DW+2 cycles later matches the new value within ±1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| level_i | input | DW | Unsigned level, sampled on every rising edge |
| pulse_o | output | 1 | Registered pulse-density output |

## Verification
A corrupted accumulator shows up at the port as a shifted high count in the next window of 2^DW cycles. A wrapped value, for example, gives a long run of wrong decisions that pushes the count well outside ±1 of the input. A broken reset value or a missing output stage shows up within the first two cycles after reset, since `pulse_o` would rise early for large inputs. Window counts taken after mid-stream input changes expose errors in the feedback that a fresh reset would hide.

// File: rtl/pdm_dac.sv
module pdm_dac #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] level_i,
  output logic          pulse_o
);
  localparam int AW = DW + 2;
  localparam logic [AW-1:0] ACC_INIT = AW'(1) << DW;

  logic [AW-1:0] acc_q;
  logic [AW-1:0] fbk;
  logic [AW-1:0] diff;
  logic [AW-1:0] acc_d;

  assign fbk   = {acc_q[AW-1], acc_q[AW-1], {DW{1'b0}}};
  assign diff  = {2'b00, level_i} + fbk;
  assign acc_d = diff + acc_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      acc_q   <= ACC_INIT;
      pulse_o <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      pulse_o <= acc_q[AW-1];
    end
  end
endmodule

module pdm_dac_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] level_i,
  input logic [DW+1:0] acc_q,
  input logic          pulse_o
);
  localparam int AW = DW + 2;

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_q[AW-1:AW-2] == 2'b01) || (acc_q[AW-1:AW-2] == 2'b10));

  // R6
  fall_on_high_chk: assert property (@(posedge clk) disable iff (rst)
    acc_q[AW-1] |=> (acc_q < $past(acc_q)));

  // R6
  rise_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_q[AW-1] |=> (acc_q >= $past(acc_q)));

  // R4
  reset_release_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pulse_o);

  // R1
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((level_i == '0) && !acc_q[AW-1] && !pulse_o) |=> !pulse_o);
endmodule

bind pdm_dac pdm_dac_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .level_i(level_i), .acc_q(acc_q), .pulse_o(pulse_o)
);

// File: tb/pdm_dac_tb.sv
module pdm_dac_tb;
  localparam int DW  = 6;
  localparam int WIN = 1 << DW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] level = '0;
  logic pulse;
  int checks = 0;
  int fails  = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  pdm_dac #(.DW(DW)) u_dut (.clk(clk), .rst(rst), .level_i(level), .pulse_o(pulse));

  task automatic check(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic count_win(input int len, output int n);
    n = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      n += int'(pulse);
    end
  endtask

  task automatic do_reset(input logic [DW-1:0] v);
    @(negedge clk);
    rst = 1'b1;
    level = v;
    @(negedge clk);
    check("R4 during reset", int'(pulse), 0, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R4 first edge", int'(pulse), 0, 0);
    @(negedge clk);
    check("R4 second edge", int'(pulse), 0, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    // R1: zero input gives a silent stream from reset
    do_reset('0);
    count_win(4 * WIN, n);
    check("R1 zero level", n, 0, 0);

    // R2: full scale over a long window
    do_reset('1);
    count_win(WIN + 2, n);
    count_win(4 * WIN, n);
    check("R2 full scale", n, 4 * (WIN - 1) - 1, 4 * (WIN - 1) + 1);

    // R3: exhaustive sweep of every level after a fresh reset
    for (int v = 0; v < WIN; v++) begin
      do_reset(DW'(v));
      count_win(WIN + 2, n);
      count_win(WIN, n);
      check("R3 level sweep", n, v - 1, v + 1);
      count_win(WIN, n);
      check("R3 level sweep 2nd window", n, v - 1, v + 1);
    end

    // R7: mid-stream changes, no reset in between (R5/R6 watched by assertions)
    do_reset(DW'(WIN / 2));
    for (int k = 0; k < 40; k++) begin
      int v;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      v = (k % 8 == 0) ? WIN - 1 : (k % 8 == 4) ? 0 : int'(lfsr[DW-1:0]);
      level = DW'(v);
      count_win(WIN + 2, n);
      count_win(WIN, n);
      check("R7 mid-stream change", n, v - 1, v + 1);
    end

    finish_run();
  end
endmodule